// File: doc/BRIEF.md
# Bit-Slice Integer ALU

A combinational integer arithmetic logic unit built from one replicated single-bit cell. Each cell holds a full adder, an AND gate, an OR gate and a four-way result selector. A 3-bit operation code picks bitwise AND, bitwise OR, addition, subtraction or signed set-on-less-than. Four outputs come back in the same cycle: the result word, a zero flag, a signed overflow flag and the carry out of the top cell.

The top bit of the operation code does two jobs. It inverts the second operand in every cell, and it becomes the carry into cell 0, so the adder chain computes a + ~b + 1 for subtraction. The low two bits steer the selector in every cell. Set-on-less-than feeds the sum bit of the top cell back into the spare selector input of cell 0, and ties that input to 0 in all other cells. The unit has no clock and no handshake, so operands and code simply sit on the inputs and the outputs follow.

Top module: `slice_alu`

## Requirements
- R1: Code 3'b000 gives result = a AND b, bit by bit.
- R2: Code 3'b001 gives result = a OR b, bit by bit.
- R3: Code 3'b010 gives result = (a + b) mod 2^32.
- R4: Code 3'b110 gives result = (a - b) mod 2^32, computed as a + ~b + 1.
- R5: Code 3'b111 gives result bit 0 = bit 31 of (a - b) mod 2^32, and result bits 31..1 = 0.
- R6: zero_o is 1 exactly when all 32 result bits are 0, under every code.
- R7: For codes 010, 110 and 111, ovf_o is the carry into bit 31 XOR the carry out of bit 31. An addition of operands with different sign bits never overflows, and a subtraction of operands with equal sign bits never overflows.
- R8: For codes 010, 110 and 111, cout_o is the carry out of bit 31. For a subtraction it is 1 exactly when a >= b taken as unsigned values.
- R9: For codes 000 and 001, ovf_o and cout_o are both 0.
- R10: Codes 011, 100 and 101 are not used. For these codes the result is all zeros, zero_o is 1, and ovf_o and cout_o are 0, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First operand a |
| opb_i | input | 32 | Second operand b |
| op_i | input | 3 | Operation code |
| result_o | output | 32 | Result word |
| zero_o | output | 1 | High when the result is all zeros |
| ovf_o | output | 1 | Signed overflow of the arithmetic operation |
| cout_o | output | 1 | Carry out of the most significant cell |

## Verification
All four outputs are due in the same cycle as the operands and code. There is no register anywhere in the path, so the latency is zero cycles. The bench drives a new stimulus one time unit after a rising edge and queues the expected values at the same time. A monitor then compares the outputs at the falling edge that follows, which gives the carry chain half a period to settle and keeps every comparison clear of the edge where the inputs change. Operands are drawn from 0, 1, all ones, the largest positive value and the most negative value, crossed with all eight codes, plus random pairs.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_AND  = 3'b000,
    OP_OR   = 3'b001,
    OP_ADD  = 3'b010,
    OP_SUB  = 3'b110,
    OP_SLT  = 3'b111
  } alu_op_e;

  // per-cell selector codes, taken from the low two opcode bits
  localparam logic [1:0] SEL_AND  = 2'd0;
  localparam logic [1:0] SEL_OR   = 2'd1;
  localparam logic [1:0] SEL_SUM  = 2'd2;
  localparam logic [1:0] SEL_LESS = 2'd3;
endpackage

// File: rtl/alu_ctrl_decode.sv
module alu_ctrl_decode
  import alu_pkg::*;
(
  input  logic [2:0] op_i,
  output logic       binv_o,
  output logic [1:0] sel_o,
  output logic       legal_o,
  output logic       arith_o
);
  always_comb begin
    binv_o = op_i[2];
    sel_o  = op_i[1:0];
    unique case (op_i)
      OP_AND, OP_OR:          begin legal_o = 1'b1; arith_o = 1'b0; end
      OP_ADD, OP_SUB, OP_SLT: begin legal_o = 1'b1; arith_o = 1'b1; end
      default:                begin legal_o = 1'b0; arith_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       cin_i,
  input  logic       less_i,
  input  logic       binv_i,
  input  logic [1:0] sel_i,
  output logic       res_o,
  output logic       sum_o,
  output logic       cout_o
);
  logic bx;

  always_comb begin
    bx     = b_i ^ binv_i;
    sum_o  = a_i ^ bx ^ cin_i;
    cout_o = (a_i & bx) | (a_i & cin_i) | (bx & cin_i);
    unique case (sel_i)
      SEL_AND: res_o = a_i & bx;
      SEL_OR:  res_o = a_i | bx;
      SEL_SUM: res_o = sum_o;
      default: res_o = less_i;
    endcase
  end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] word_i,
  output logic             zero_o
);
  assign zero_o = ~(|word_i);
endmodule

// File: rtl/slice_alu.sv
module slice_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             cout_o
);
  localparam int MSB = WIDTH - 1;

  logic             binv;
  logic [1:0]       sel;
  logic             legal;
  logic             arith;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sum_w;
  logic [WIDTH-1:0] raw_res;
  logic             set_bit;

  alu_ctrl_decode u_dec (
    .op_i    (op_i),
    .binv_o  (binv),
    .sel_o   (sel),
    .legal_o (legal),
    .arith_o (arith)
  );

  // carry into cell 0 is the same wire as the operand inverter
  assign carry[0] = binv;
  assign set_bit  = sum_w[MSB];

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic less_in;
    if (i == 0) begin : g_lsb
      assign less_in = set_bit;
    end else begin : g_rest
      assign less_in = 1'b0;
    end

    alu_bit_slice u_cell (
      .a_i    (opa_i[i]),
      .b_i    (opb_i[i]),
      .cin_i  (carry[i]),
      .less_i (less_in),
      .binv_i (binv),
      .sel_i  (sel),
      .res_o  (raw_res[i]),
      .sum_o  (sum_w[i]),
      .cout_o (carry[i+1])
    );
  end

  assign result_o = legal ? raw_res : '0;
  assign ovf_o    = arith & (carry[MSB] ^ carry[WIDTH]);
  assign cout_o   = arith & carry[WIDTH];

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .word_i (result_o),
    .zero_o (zero_o)
  );
endmodule

// File: rtl/slice_alu_checker.sv
module slice_alu_checker #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opa_i,
  input logic [WIDTH-1:0] opb_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             ovf_o,
  input logic             cout_o
);
  localparam int MSB = WIDTH - 1;
  logic [WIDTH-1:0] diff;

  always_comb begin
    diff = opa_i - opb_i;
    p_zero_flag_r6: assert (zero_o == (result_o == '0))
      else $error("zero flag does not match result");
    if (op_i == 3'b110) begin
      p_sub_value_r4: assert (result_o == diff)
        else $error("subtract result wrong");
      p_sub_same_sign_r7: assert (!(opa_i[MSB] == opb_i[MSB] && ovf_o))
        else $error("overflow on same-sign subtract");
    end
    if (op_i == 3'b010) begin
      p_add_mixed_sign_r7: assert (!(opa_i[MSB] != opb_i[MSB] && ovf_o))
        else $error("overflow on mixed-sign add");
    end
    if (op_i == 3'b111) begin
      p_slt_upper_r5: assert (result_o[WIDTH-1:1] == '0)
        else $error("set-less-than upper bits not zero");
    end
    if (op_i == 3'b000 || op_i == 3'b001) begin
      p_logic_flags_r9: assert (!ovf_o && !cout_o)
        else $error("flags raised on logic op");
    end
    if (op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101) begin
      p_unused_code_r10: assert (result_o == '0 && zero_o && !ovf_o && !cout_o)
        else $error("unused code produced output");
    end
  end
endmodule

bind slice_alu slice_alu_checker #(.WIDTH(WIDTH)) u_chk (
  .opa_i    (opa_i),
  .opb_i    (opb_i),
  .op_i     (op_i),
  .result_o (result_o),
  .zero_o   (zero_o),
  .ovf_o    (ovf_o),
  .cout_o   (cout_o)
);

// File: tb/slice_alu_bench.sv
`timescale 1ns/1ps
module slice_alu_bench;
  typedef struct {
    logic [31:0] a;
    logic [31:0] b;
    logic [2:0]  op;
    logic [31:0] res;
    logic        zero;
    logic        ovf;
    logic        cout;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [2:0]  op = 3'b000;
  logic [31:0] result;
  logic        zero, ovf, cout;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  slice_alu u_slice_alu (
    .opa_i(opa), .opb_i(opb), .op_i(op),
    .result_o(result), .zero_o(zero), .ovf_o(ovf), .cout_o(cout)
  );

  function automatic exp_t model(logic [31:0] a, logic [31:0] b, logic [2:0] c);
    exp_t e;
    logic [32:0] s;
    e.a = a; e.b = b; e.op = c;
    e.res = '0; e.ovf = 1'b0; e.cout = 1'b0;
    case (c)
      3'b000: e.res = a & b;
      3'b001: e.res = a | b;
      3'b010: begin
        s = {1'b0, a} + {1'b0, b};
        e.res = s[31:0]; e.cout = s[32];
        e.ovf = (a[31] == b[31]) && (s[31] != a[31]);
      end
      3'b110, 3'b111: begin
        s = {1'b0, a} + {1'b0, ~b} + 33'd1;
        e.cout = s[32];
        e.ovf = (a[31] != b[31]) && (s[31] != a[31]);
        e.res = (c == 3'b110) ? s[31:0] : {31'd0, s[31]};
      end
      default: e.res = '0;
    endcase
    e.zero = (e.res == '0);
    return e;
  endfunction

  function automatic string res_tag(logic [2:0] c);
    case (c)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      default: return "R10";
    endcase
  endfunction

  function automatic string flag_tag(logic [2:0] c, bit is_cout);
    case (c)
      3'b000, 3'b001: return "R9";
      3'b010, 3'b110, 3'b111: return is_cout ? "R8" : "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, exp_t e);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", tag, e.op, e.a, e.b, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] a, logic [31:0] b, logic [2:0] c);
    @(posedge clk);
    #1;
    opa = a; opb = b; op = c;
    sb_q.push_back(model(a, b, c));
  endtask

  // monitor: one comparison per falling edge while items are queued
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(res_tag(e.op), result, e.res, e);
      check("R6", {31'd0, zero}, {31'd0, e.zero}, e);
      check(flag_tag(e.op, 1'b0), {31'd0, ovf}, {31'd0, e.ovf}, e);
      check(flag_tag(e.op, 1'b1), {31'd0, cout}, {31'd0, e.cout}, e);
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] corner [5];
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
    corner[2] = 32'hFFFF_FFFF; corner[3] = 32'h7FFF_FFFF;
    corner[4] = 32'h8000_0000;
    repeat (3) @(posedge clk);
    #1;
    // reset state: zero operands, code 000 -> result 0, zero flag set (R1, R6)
    checks++;
    if (result !== 32'd0 || zero !== 1'b1 || ovf !== 1'b0 || cout !== 1'b0) begin
      errors++;
      $display("FAIL R6 reset state actual=%h/%b expected=00000000/1", result, zero);
    end
    rst_n = 1'b1;
    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          drive(corner[i], corner[j], 3'(c));
    // directed: R5 with overflow, R8 equal operands, R10 with busy operands
    drive(32'h8000_0000, 32'h0000_0001, 3'b111);
    drive(32'h1234_5678, 32'h1234_5678, 3'b110);
    drive(32'hDEAD_BEEF, 32'hCAFE_F00D, 3'b011);
    drive(32'hDEAD_BEEF, 32'hCAFE_F00D, 3'b100);
    drive(32'hDEAD_BEEF, 32'hCAFE_F00D, 3'b101);
    for (int k = 0; k < 400; k++) begin
      logic [2:0] cc;
      case (k % 5)
        0: cc = 3'b000; 1: cc = 3'b001; 2: cc = 3'b010;
        3: cc = 3'b110; default: cc = 3'b111;
      endcase
      drive($urandom, $urandom, cc);
    end
    while (sb_q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule